// File: doc/BRIEF.md
# Pilot Carrier Channel Interpolator

This block produces a complete channel estimate for a single user of a multi-carrier uplink. During the shared pilot slot the user transmits pilot tones on only a few carriers, and it may use a different carrier in each symbol of the slot. The block watches a stream of complex FFT bins, each tagged with its used-carrier index. It keeps the bins that fall on this user's pilot positions and ignores all other bins.

On a start pulse the block walks the used carriers from index 0 upward and emits one complex estimate per accepted beat on a valid/ready stream. A carrier between two pilots receives a linear blend of those two pilots. A carrier outside the pilot span copies the nearest pilot.

The pilot positions form an evenly spaced table: the first pilot sits at carrier `FIRST_PIL`, and pilot k sits at `FIRST_PIL + k*2^SPC_LOG2`. Because the spacing is a power of two, the interpolation weight reduces to a mask and a shift.

Top module: `chan_interp`

## Requirements
- R1: After reset `est_valid` is low and every stored pilot is zero, so a stream started before any pilot arrives yields all-zero estimates.
- R2: A beat with `pil_valid` high and `pil_car` equal to a pilot position stores (`pil_re`, `pil_im`) for that pilot, and a later write replaces an earlier one. A beat on any other carrier changes no stored pilot. With the defaults (48 carriers, `FIRST_PIL`=4, spacing 8, 6 pilots) the pilot positions are carriers 4, 12, 20, 28, 36 and 44.
- R3: A `start` pulse while idle raises `est_valid` on the next clock with `est_car`=0. Each accepted beat (`est_valid` and `est_ready`) advances `est_car` by one.
- R4: `est_last` is high exactly while carrier NUM_CAR-1 is offered. After that beat is accepted, `est_valid` is low.
- R5: While `est_valid` is high and `est_ready` is low, `est_car`, `est_re`, `est_im` and `est_last` hold their values.
- R6: Carriers at or below the first pilot position output the first pilot. Carriers at or above the last pilot position output the last pilot.
- R7: For carrier c with pilot k at position p_k ≤ c < p_k+S (S = 2^SPC_LOG2), each 12-bit two's complement component equals P_k + floor((P_k+1 − P_k)·(c − p_k)/S). At c = p_k this gives exactly P_k.
- R8: While the stream is active, `pil_valid` writes and `start` pulses are ignored. The stored pilots and the carrier sequence are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pil_valid | input | 1 | FFT bin present on the pilot input |
| pil_car | input | 6 | Used-carrier index of the bin |
| pil_re | input | 12 | Real part of the bin, signed |
| pil_im | input | 12 | Imaginary part of the bin, signed |
| start | input | 1 | Pulse that begins an estimate stream |
| est_ready | input | 1 | Downstream accepts the current estimate |
| est_valid | output | 1 | Estimate offered |
| est_car | output | 6 | Carrier index of the offered estimate |
| est_re | output | 12 | Real part of the estimate, signed |
| est_im | output | 12 | Imaginary part of the estimate, signed |
| est_last | output | 1 | Offered estimate is for the final carrier |

## Verification
The interpolation is tried with five pilot patterns:
- an all-zero store, straight after reset;
- rising ramps on both components, where rounding is checked on positive slopes;
- alternating full-scale extremes (−2048/2047), where floor rounding on negative slopes and the absence of overflow are exposed;
- pilots delivered out of order and overwritten, which separates last-write-wins from first-write capture;
- a stray write to a non-pilot carrier, which would distort the interpolated value at that carrier.

Streams run with steady and stalling `est_ready`. The stalling runs show whether data and index hold under back-pressure. In one stream, a pilot write and a restart pulse arrive mid-stream, and any effect they have would show up in the carriers that follow.

// File: rtl/chan_interp_pkg.sv
package chan_interp_pkg;
  localparam int SAMP_W = 12;

  typedef logic signed [SAMP_W-1:0] samp_t;

  typedef struct packed {
    samp_t re;
    samp_t im;
  } cplx_t;

  // Blend of a toward b by off/2^sh, floor rounding.
  function automatic samp_t lerp_comp(input samp_t a, input samp_t b,
                                      input int off, input int sh);
    int diff;
    int prod;
    diff = int'(b) - int'(a);
    prod = (diff * off) >>> sh;
    return samp_t'(int'(a) + prod);
  endfunction

  function automatic cplx_t lerp_cplx(input cplx_t a, input cplx_t b,
                                      input int off, input int sh);
    cplx_t r;
    r.re = lerp_comp(a.re, b.re, off, sh);
    r.im = lerp_comp(a.im, b.im, off, sh);
    return r;
  endfunction
endpackage

// File: rtl/chan_interp_store.sv
module chan_interp_store
  import chan_interp_pkg::*;
#(
  parameter int NUM_CAR   = 48,
  parameter int NUM_PIL   = 6,
  parameter int FIRST_PIL = 4,
  parameter int SPC_LOG2  = 3,
  localparam int CAR_W    = $clog2(NUM_CAR)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [CAR_W-1:0]         wr_car,
  input  cplx_t                    wr_val,
  output cplx_t [NUM_PIL-1:0]      pil_q
);
  logic [NUM_PIL-1:0] hit;

  for (genvar k = 0; k < NUM_PIL; k++) begin : g_pil
    localparam int POS = FIRST_PIL + (k << SPC_LOG2);
    assign hit[k] = wr_en && (wr_car == CAR_W'(POS));

    always_ff @(posedge clk) begin
      if (!rst_n)      pil_q[k] <= '0;
      else if (hit[k]) pil_q[k] <= wr_val;
    end

    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      hit[k] |=> pil_q[k] == $past(wr_val));
    a_r2_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      !hit[k] |=> $stable(pil_q[k]));
  end

  a_r2_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/chan_interp_seq.sv
module chan_interp_seq #(
  parameter int NUM_CAR = 48,
  localparam int CAR_W  = $clog2(NUM_CAR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ready,
  output logic             active,
  output logic [CAR_W-1:0] car,
  output logic             last,
  output logic             beat
);
  localparam logic [CAR_W-1:0] LAST_CAR = CAR_W'(NUM_CAR - 1);

  assign last = active && (car == LAST_CAR);
  assign beat = active && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      car    <= '0;
    end else if (!active && start) begin
      active <= 1'b1;
      car    <= '0;
    end else if (beat) begin
      if (car == LAST_CAR) active <= 1'b0;
      else                 car    <= car + 1'b1;
    end
  end

  a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && start) |=> active && car == '0);
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !last) |=> active && car == $past(car) + 1'b1);
  a_r4_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && last) |=> !active);
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ready) |=> active && $stable(car));
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (active && start && !ready) |=> $stable(car));
endmodule

// File: rtl/chan_interp_core.sv
module chan_interp_core
  import chan_interp_pkg::*;
#(
  parameter int NUM_CAR   = 48,
  parameter int NUM_PIL   = 6,
  parameter int FIRST_PIL = 4,
  parameter int SPC_LOG2  = 3,
  localparam int CAR_W    = $clog2(NUM_CAR),
  localparam int IDX_W    = (NUM_PIL > 1) ? $clog2(NUM_PIL) : 1,
  localparam int SPAN     = (NUM_PIL - 1) << SPC_LOG2,
  localparam int OFF_MASK = (1 << SPC_LOG2) - 1
) (
  input  logic [CAR_W-1:0]    car,
  input  cplx_t [NUM_PIL-1:0] pil_q,
  output cplx_t               est
);
  int               rel;
  int               off;
  logic [IDX_W-1:0] seg;
  logic [IDX_W-1:0] seg_n;

  always_comb begin
    rel   = int'(car) - FIRST_PIL;
    off   = rel & OFF_MASK;
    seg   = IDX_W'(rel >>> SPC_LOG2);
    seg_n = seg + 1'b1;
    if (rel <= 0)
      est = pil_q[0];
    else if (rel >= SPAN)
      est = pil_q[NUM_PIL-1];
    else
      est = lerp_cplx(pil_q[seg], pil_q[seg_n], off, SPC_LOG2);
  end
endmodule

// File: rtl/chan_interp.sv
module chan_interp
  import chan_interp_pkg::*;
#(
  parameter int NUM_CAR   = 48,
  parameter int NUM_PIL   = 6,
  parameter int FIRST_PIL = 4,
  parameter int SPC_LOG2  = 3,
  localparam int CAR_W    = $clog2(NUM_CAR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pil_valid,
  input  logic [CAR_W-1:0]  pil_car,
  input  logic [SAMP_W-1:0] pil_re,
  input  logic [SAMP_W-1:0] pil_im,
  input  logic              start,
  input  logic              est_ready,
  output logic              est_valid,
  output logic [CAR_W-1:0]  est_car,
  output logic [SAMP_W-1:0] est_re,
  output logic [SAMP_W-1:0] est_im,
  output logic              est_last
);
  cplx_t [NUM_PIL-1:0] pil_q;
  cplx_t               wr_val;
  cplx_t               est;
  logic                active;
  logic                beat;
  logic                wr_en;

  assign wr_en     = pil_valid && !active;
  assign wr_val.re = samp_t'(pil_re);
  assign wr_val.im = samp_t'(pil_im);

  chan_interp_store #(
    .NUM_CAR(NUM_CAR), .NUM_PIL(NUM_PIL),
    .FIRST_PIL(FIRST_PIL), .SPC_LOG2(SPC_LOG2)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_car(pil_car), .wr_val(wr_val), .pil_q(pil_q)
  );

  chan_interp_seq #(.NUM_CAR(NUM_CAR)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(est_ready),
    .active(active), .car(est_car), .last(est_last), .beat(beat)
  );

  chan_interp_core #(
    .NUM_CAR(NUM_CAR), .NUM_PIL(NUM_PIL),
    .FIRST_PIL(FIRST_PIL), .SPC_LOG2(SPC_LOG2)
  ) u_core (
    .car(est_car), .pil_q(pil_q), .est(est)
  );

  assign est_valid = active;
  assign est_re    = est.re;
  assign est_im    = est.im;

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |=> $stable(pil_q));
  a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (est_valid && !est_ready) |=> $stable(est_re) && $stable(est_im) && $stable(est_last));
  a_r6_low_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (est_valid && est_car == '0) |-> est == pil_q[0]);
  a_r4_last_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (est_valid && est_last) |-> est_car == CAR_W'(NUM_CAR - 1));
endmodule

// File: tb/chan_interp_test.sv
module chan_interp_test;
  localparam int NC = 48;
  localparam int NP = 6;
  localparam int P0 = 4;
  localparam int SP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pil_valid = 1'b0;
  logic [5:0]  pil_car = '0;
  logic [11:0] pil_re = '0;
  logic [11:0] pil_im = '0;
  logic        start = 1'b0;
  logic        est_ready = 1'b0;
  logic        est_valid;
  logic [5:0]  est_car;
  logic [11:0] est_re;
  logic [11:0] est_im;
  logic        est_last;

  int checks = 0;
  int errors = 0;
  int pre[NP];
  int pim[NP];

  chan_interp uut (
    .clk(clk), .rst_n(rst_n), .pil_valid(pil_valid), .pil_car(pil_car),
    .pil_re(pil_re), .pil_im(pil_im), .start(start), .est_ready(est_ready),
    .est_valid(est_valid), .est_car(est_car), .est_re(est_re),
    .est_im(est_im), .est_last(est_last)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Model: locate the surrounding pilots by search, blend with floor division.
  function automatic int model(input int c, input int v[NP]);
    int num;
    int q;
    if (c <= P0) return v[0];
    if (c >= P0 + (NP-1)*SP) return v[NP-1];
    for (int k = 0; k < NP-1; k++) begin
      if (c >= P0 + k*SP && c < P0 + (k+1)*SP) begin
        num = (v[k+1] - v[k]) * (c - (P0 + k*SP));
        q = (num >= 0) ? num / SP : -((-num + SP - 1) / SP);
        return v[k] + q;
      end
    end
    return 0;
  endfunction

  task automatic write_pil(input int car, input int re, input int im);
    @(negedge clk);
    pil_valid = 1'b1; pil_car = 6'(car); pil_re = 12'(re); pil_im = 12'(im);
    @(negedge clk);
    pil_valid = 1'b0;
  endtask

  task automatic load_all(input string tag);
    for (int k = NP-1; k >= 0; k--) write_pil(P0 + k*SP, pre[k], pim[k]);
  endtask

  task automatic check_beat(input int b, input bit stalled);
    string dreq;
    dreq = (b <= P0 || b >= P0 + (NP-1)*SP) ? "R6" : "R7";
    chk(est_valid == 1'b1, stalled ? "R5" : "R3", "valid", int'(est_valid), 1);
    chk(int'(est_car) == b, stalled ? "R5" : "R3", "carrier", int'(est_car), b);
    chk(int'($signed(est_re)) == model(b, pre), dreq, "real", int'($signed(est_re)), model(b, pre));
    chk(int'($signed(est_im)) == model(b, pim), dreq, "imag", int'($signed(est_im)), model(b, pim));
    chk(est_last == (b == NC-1), "R4", "last", int'(est_last), int'(b == NC-1));
  endtask

  // mode 0: ready every cycle; mode 1: stall b%3 cycles before each beat.
  task automatic run_stream(input int mode, input bit disturb);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int b = 0; b < NC; b++) begin
      int stalls;
      stalls = (mode == 1) ? (b % 3) : 0;
      for (int s = 0; s < stalls; s++) begin
        check_beat(b, s > 0);
        est_ready = 1'b0;
        @(negedge clk);
      end
      check_beat(b, stalls > 0);
      est_ready = 1'b1;
      if (disturb && b == 2) begin   // R8: write on pilot 4 and restart mid-stream
        pil_valid = 1'b1; pil_car = 6'(P0); pil_re = 12'(999); pil_im = 12'(-999);
        start = 1'b1;
      end
      @(negedge clk);
      est_ready = 1'b0; pil_valid = 1'b0; start = 1'b0;
    end
    chk(est_valid == 1'b0, "R4", "valid after last", int'(est_valid), 0);
  endtask

  task automatic t_reset;
    chk(est_valid == 1'b0, "R1", "valid at reset", int'(est_valid), 0);
    for (int k = 0; k < NP; k++) begin pre[k] = 0; pim[k] = 0; end
    run_stream(0, 1'b0);   // R1: empty store gives zeros
  endtask

  task automatic t_ramp;
    for (int k = 0; k < NP; k++) begin pre[k] = 100*k - 250; pim[k] = 37*k*k + 5; end
    load_all("ramp");
    run_stream(0, 1'b0);   // R6 R7 positive slopes
  endtask

  task automatic t_extreme;
    for (int k = 0; k < NP; k++) begin
      pre[k] = (k % 2) ? 2047 : -2048;
      pim[k] = (k % 2) ? -2048 : 2047;
    end
    load_all("extreme");
    run_stream(1, 1'b0);   // R5 stalls, R7 negative slopes
  endtask

  task automatic t_overwrite;
    for (int k = 0; k < NP; k++) begin pre[k] = -7*k; pim[k] = 3*k + 1; end
    load_all("first");
    write_pil(P0 + 2*SP, 1, 1);          // stale
    write_pil(P0 + 2*SP, 500, -300);     // R2: latest wins
    pre[2] = 500; pim[2] = -300;
    write_pil(P0 + 1, 1500, 1500);       // R2: non-pilot carrier ignored
    write_pil(NC - 1, -1500, 900);       // R2: non-pilot carrier ignored
    run_stream(1, 1'b0);
  endtask

  task automatic t_disturb;
    for (int k = 0; k < NP; k++) begin pre[k] = 60*k + 11; pim[k] = -45*k; end
    load_all("dist");
    run_stream(0, 1'b1);   // R8
    run_stream(0, 1'b0);   // R8: store still holds pre-stream pilots
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ramp();
    t_extreme();
    t_overwrite();
    t_disturb();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule